// File: doc/BRIEF.md
# Timestamp Queuing Arbiter

This block shares one resource among a set of requesters and serves them strictly in the order in which they first asked. A free-running time counter supplies a stamp, and each requester keeps a copy of the counter value from the cycle in which its request was first seen. Whenever the resource is free, the arbiter grants the waiting requester whose stamp is oldest. The grant stays on that requester until it pulses `done_i`. That pulse ends the service and frees the requester's stamp.

Ages are measured as the wrapped difference between the current time and each stored stamp. The counter can therefore roll over without reversing the order, provided no request waits longer than the counter's range. The stamp width comes from the requester count, the longest service time and the tick interval of the counter: the range covers twice the requester count times the longest service, divided by the tick interval. Requests stamped in the same tick go to the lower index first.

Top module: `stamp_queue_arbiter`

## Requirements
- R1: After reset, `grant_o` is all zeros and the time counter is zero.
- R2: The time counter advances by one every TICK_DIV clock cycles and wraps modulo 2^W, where W = clog2(ceil(2*NUM_REQ*MAX_SERVICE/TICK_DIV)). With the defaults (4, 8, 1), W is 6. A requester that holds no stamp and is sampled with its `req_i` bit high at a rising edge stores the counter value at that edge.
- R3: `grant_o` is zero or one-hot, and bit i selects requester i. When no grant is active at an edge, the arbiter grants, at that edge, the stamped and still-requesting requester with the largest wrapped age (now - stamp mod 2^W). A request first sampled at edge k with the resource free is granted at edge k+1.
- R4: Requesters whose stamps are equal are served in ascending index order. Index 0 has the highest priority.
- R5: Arrival order is kept across a wrap of the time counter, as long as every wait is shorter than 2^W ticks.
- R6: An active grant stays unchanged while `done_i` is low, even if the owner drops its request.
- R7: `done_i` high while a grant is active clears `grant_o` at the next edge and frees the owner's stamp. No new grant is issued at that same edge. If the owner's request is still high, it takes a fresh stamp and queues behind the earlier arrivals.
- R8: A stamped requester whose request drops before it is granted loses its stamp. If it asserts again later, it is stamped anew and queues behind requests that arrived in the meantime.
- R9: `done_i` has no effect while no grant is active.
- R10: A grant is issued only to a requester whose `req_i` bit was high in the cycle before the grant appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Request level per requester |
| done_i | input | 1 | Single-cycle pulse that ends the current service |
| grant_o | output | NUM_REQ | One-hot grant, or zero when the resource is idle |

## Verification
The hardest case to reach from the ports is a queue whose stamps straddle a rollover of the time counter. That is the only case in which a plain magnitude comparison and the wrapped-age comparison give different winners. The counter starts at zero on reset and advances once per cycle in the bench configuration. The bench counts cycles from reset, raises one request a few ticks before the rollover and another a few ticks after it, and holds an earlier owner in service until both are waiting. A full sweep over all arrival permutations, started at varying offsets, then places further rollovers at many points in the queue.

// File: rtl/sqa_pkg.sv
package sqa_pkg;

  // Stamp width: enough bits to cover 2*n*tmax cycles counted in ticks of `tick` cycles.
  function automatic int unsigned stamp_width(input int unsigned n,
                                              input int unsigned tmax,
                                              input int unsigned tick);
    int unsigned span;
    int unsigned w;
    span = (2 * n * tmax + tick - 1) / tick;
    w = 1;
    while (w < 31 && (32'd1 << w) < span) w = w + 1;
    return w;
  endfunction

  // Age of a stamp relative to the current time, modulo 2^w.
  function automatic logic [31:0] wrap_age(input logic [31:0] now,
                                           input logic [31:0] stamp,
                                           input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (now - stamp) & mask;
  endfunction

  // True when age a should beat the current best age b (strictly older).
  function automatic logic beats(input logic [31:0] a, input logic [31:0] b);
    return a > b;
  endfunction

endpackage

// File: rtl/sqa_time_base.sv
module sqa_time_base #(
  parameter int unsigned TICK_DIV = 1,
  parameter int unsigned STAMP_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [STAMP_W-1:0] now_o
);

  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate

  logic [STAMP_W-1:0] now_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    now_q <= '0;
    else if (tick) now_q <= now_q + 1'b1;
  end

  assign now_o = now_q;

endmodule

// File: rtl/sqa_req_slot.sv
module sqa_req_slot #(
  parameter int unsigned STAMP_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [STAMP_W-1:0] now_i,
  input  logic               granted_i,
  input  logic               release_i,
  output logic               held_o,
  output logic [STAMP_W-1:0] stamp_o
);

  logic               held_q;
  logic [STAMP_W-1:0] stamp_q;

  // Events named for visibility.
  logic capture_w;
  logic withdraw_w;
  assign capture_w  = !held_q && req_i && !release_i;
  assign withdraw_w = held_q && !req_i && !granted_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      stamp_q <= '0;
    end else if (release_i) begin
      held_q  <= 1'b0;
    end else if (withdraw_w) begin
      held_q  <= 1'b0;
    end else if (capture_w) begin
      held_q  <= 1'b1;
      stamp_q <= now_i;
    end
  end

  assign held_o  = held_q;
  assign stamp_o = stamp_q;

endmodule

// File: rtl/sqa_oldest_pick.sv
module sqa_oldest_pick #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned STAMP_W = 6,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [STAMP_W-1:0]              now_i,
  input  logic [NUM_REQ-1:0]              elig_i,
  input  logic [NUM_REQ-1:0][STAMP_W-1:0] stamp_i,
  output logic [NUM_REQ-1:0][STAMP_W-1:0] age_o,
  output logic                            found_o,
  output logic [IDX_W-1:0]                win_idx_o,
  output logic [STAMP_W-1:0]              win_age_o
);

  logic [NUM_REQ-1:0][STAMP_W-1:0] age_w;

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_age
      logic [31:0] full_age;
      assign full_age = sqa_pkg::wrap_age(32'(now_i), 32'(stamp_i[i]), STAMP_W);
      assign age_w[i] = full_age[STAMP_W-1:0];
    end
  endgenerate

  // Linear scan; strict comparison keeps the lower index on equal ages.
  always_comb begin
    found_o   = 1'b0;
    win_idx_o = '0;
    win_age_o = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig_i[i] &&
          (!found_o || sqa_pkg::beats(32'(age_w[i]), 32'(win_age_o)))) begin
        found_o   = 1'b1;
        win_idx_o = IDX_W'(i);
        win_age_o = age_w[i];
      end
    end
  end

  assign age_o = age_w;

endmodule

// File: rtl/sqa_grant_ctrl.sv
module sqa_grant_ctrl #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               found_i,
  input  logic [IDX_W-1:0]   win_idx_i,
  input  logic               done_i,
  output logic [NUM_REQ-1:0] grant_o,
  output logic               issue_o,
  output logic [NUM_REQ-1:0] release_o
);

  logic [NUM_REQ-1:0] grant_q;
  logic               busy_w;
  logic               finish_w;

  assign busy_w    = |grant_q;
  assign finish_w  = busy_w && done_i;
  assign issue_o   = !busy_w && found_i;
  assign release_o = grant_q & {NUM_REQ{done_i}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        grant_q <= '0;
    else if (finish_w) grant_q <= '0;
    else if (issue_o)  grant_q <= NUM_REQ'(1) << win_idx_i;
  end

  assign grant_o = grant_q;

endmodule

// File: rtl/stamp_queue_arbiter.sv
module stamp_queue_arbiter #(
  parameter int unsigned NUM_REQ     = 4,
  parameter int unsigned MAX_SERVICE = 8,
  parameter int unsigned TICK_DIV    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               done_i,
  output logic [NUM_REQ-1:0] grant_o
);

  localparam int unsigned STAMP_W = sqa_pkg::stamp_width(NUM_REQ, MAX_SERVICE, TICK_DIV);
  localparam int unsigned IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [STAMP_W-1:0]              now_w;
  logic [NUM_REQ-1:0]              held_w;
  logic [NUM_REQ-1:0]              elig_w;
  logic [NUM_REQ-1:0][STAMP_W-1:0] stamp_w;
  logic [NUM_REQ-1:0][STAMP_W-1:0] age_w;
  logic [NUM_REQ-1:0]              release_w;
  logic                            found_w;
  logic [IDX_W-1:0]                win_idx_w;
  logic [STAMP_W-1:0]              win_age_w;
  logic                            issue_w;

  sqa_time_base #(.TICK_DIV(TICK_DIV), .STAMP_W(STAMP_W)) u_time (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now_w)
  );

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
      sqa_req_slot #(.STAMP_W(STAMP_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i[i]),
        .now_i     (now_w),
        .granted_i (grant_o[i]),
        .release_i (release_w[i]),
        .held_o    (held_w[i]),
        .stamp_o   (stamp_w[i])
      );
    end
  endgenerate

  // Only slots whose request is still high compete.
  assign elig_w = held_w & req_i;

  sqa_oldest_pick #(.NUM_REQ(NUM_REQ), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_pick (
    .now_i     (now_w),
    .elig_i    (elig_w),
    .stamp_i   (stamp_w),
    .age_o     (age_w),
    .found_o   (found_w),
    .win_idx_o (win_idx_w),
    .win_age_o (win_age_w)
  );

  sqa_grant_ctrl #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .found_i   (found_w),
    .win_idx_i (win_idx_w),
    .done_i    (done_i),
    .grant_o   (grant_o),
    .issue_o   (issue_w),
    .release_o (release_w)
  );

endmodule

// File: rtl/sqa_chk.sv
module sqa_chk #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned STAMP_W = 6
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_REQ-1:0]              req_i,
  input logic                            done_i,
  input logic [NUM_REQ-1:0]              grant_o,
  input logic [NUM_REQ-1:0]              elig_w,
  input logic [NUM_REQ-1:0][STAMP_W-1:0] age_w,
  input logic                            issue_w,
  input logic [STAMP_W-1:0]              win_age_w
);

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R3
  issue_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_w |=> $onehot(grant_o));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && !done_i) |=> $stable(grant_o));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && done_i) |=> (grant_o == '0));

  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o == '0) && done_i && !issue_w) |=> (grant_o == '0));

  // R10
  grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_w |=> ((grant_o & $past(req_i)) != '0));

  generate
    for (genvar j = 0; j < NUM_REQ; j++) begin : g_age_chk
      // R3 R5
      oldest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_w && elig_w[j]) |-> (age_w[j] <= win_age_w));
    end
  endgenerate

endmodule

bind stamp_queue_arbiter sqa_chk #(.NUM_REQ(NUM_REQ), .STAMP_W(STAMP_W)) u_sqa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .done_i    (done_i),
  .grant_o   (grant_o),
  .elig_w    (elig_w),
  .age_w     (age_w),
  .issue_w   (issue_w),
  .win_age_w (win_age_w)
);

// File: tb/stamp_queue_arbiter_bench.sv
module stamp_queue_arbiter_bench;

  localparam int N = 4;
  localparam int PERIOD = 64;  // 2^W for the defaults (R2)

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         done = 1'b0;
  logic [N-1:0] grant;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  stamp_queue_arbiter u_stamp_queue_arbiter (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .done_i  (done),
    .grant_o (grant)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic serve(input int e, input string tag);
    int n = 0;
    while (grant == '0 && n < 30) begin @(negedge clk); n++; end
    check(grant == N'(1 << e), tag, int'(grant), 1 << e);
    done = 1'b1;
    req[e] = 1'b0;
    @(negedge clk);
    done = 1'b0;
    check(grant == '0, "R7", int'(grant), 0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int fact(input int n);
    int f = 1;
    for (int k = 2; k <= n; k++) f = f * k;
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int perm [N];
    bit used [N];
    int idx, pick, f, m;

    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: no grant after reset
    check(grant == '0, "R1", int'(grant), 0);

    // R9: done while idle changes nothing
    done = 1'b1; @(negedge clk); done = 1'b0;
    check(grant == '0, "R9", int'(grant), 0);

    // R3: latency, grant on edge after capture; R6: hold after owner drops
    req[2] = 1'b1;
    @(negedge clk);
    check(grant == '0, "R3", int'(grant), 0);
    @(negedge clk);
    check(grant == 4'b0100, "R3", int'(grant), 4);
    req[2] = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(grant == 4'b0100, "R6", int'(grant), 4);
    end
    done = 1'b1; @(negedge clk); done = 1'b0;
    check(grant == '0, "R7", int'(grant), 0);
    idle(2);
    // R8: requester 2 gave up its stamp while granted-then-released; nothing pending
    check(grant == '0, "R8", int'(grant), 0);

    // R9 then ordering intact: 3 before 1
    done = 1'b1; req[3] = 1'b1; @(negedge clk); done = 1'b0; req[1] = 1'b1;
    @(negedge clk);
    serve(3, "R9");
    serve(1, "R9");

    // R7: owner keeps requesting after done, rejoins behind waiting requester
    req[0] = 1'b1; @(negedge clk); req[1] = 1'b1; idle(2);
    check(grant == 4'b0001, "R7", int'(grant), 1);
    done = 1'b1; @(negedge clk); done = 1'b0;
    serve(1, "R7");
    serve(0, "R7");

    // R8: withdrawn request loses its place
    req[0] = 1'b1; idle(2);
    req[1] = 1'b1; @(negedge clk);
    req[2] = 1'b1; @(negedge clk);
    req[1] = 1'b0; @(negedge clk);
    req[1] = 1'b1; @(negedge clk);
    req[3] = 1'b1; @(negedge clk);
    serve(0, "R8");
    serve(2, "R8");
    serve(1, "R8");
    serve(3, "R8");

    // R5: stamps straddling the counter rollover
    while ((cyc % PERIOD) != 58) @(negedge clk);
    req[2] = 1'b1; @(negedge clk);
    req[1] = 1'b1; idle(8);
    req[0] = 1'b1; idle(3);
    req[3] = 1'b1; idle(10);
    serve(2, "R5");
    serve(1, "R5");
    serve(0, "R5");
    serve(3, "R5");

    // R4: every request set arriving together, ascending index order
    for (int mm = 1; mm < 16; mm++) begin
      m = mm;
      req = N'(m);
      @(negedge clk);
      for (int i = 0; i < N; i++) if (m[i]) serve(i, "R4");
      idle(1);
    end

    // R2 R3 R5: every arrival order, one cycle apart, at varying offsets
    for (int p = 0; p < 24; p++) begin
      idx = p;
      for (int i = 0; i < N; i++) used[i] = 1'b0;
      for (int s = 0; s < N; s++) begin
        f = fact(N - 1 - s);
        pick = idx / f;
        idx = idx % f;
        for (int i = 0; i < N; i++) begin
          if (!used[i]) begin
            if (pick == 0) begin perm[s] = i; used[i] = 1'b1; pick = -1; end
            else if (pick > 0) pick--;
          end
        end
      end
      idle((p * 7) % 13);
      for (int s = 0; s < N; s++) begin
        req[perm[s]] = 1'b1;
        @(negedge clk);
      end
      idle(p % 5);
      for (int s = 0; s < N; s++) serve(perm[s], "R2");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule